// File: doc/BRIEF.md
# Strap-Addressed Indirect Management Register Bridge

This block sits behind the management-interface receiver of a multi-port switch. It takes already-decoded clause-22 frames (PHY address, register number, read/write flag, write data) and decides from four strap inputs how the device answers them. With all straps low the device owns the whole 32-entry PHY address space. Each frame is forwarded straight to the internal device whose number equals the PHY address.

With any strap high the device answers only at its own even address. There, a command register and a data register form a window through which a host reaches any of the 32 internal devices. For a write, the host loads the data register and then writes a command word with the busy bit set. For a read, the host writes the command, polls until busy clears, and then reads the data register.

Internal accesses leave through a request/acknowledge register-bus master port. Read responses to the host come back as a one-cycle `rsp_valid` pulse carrying `rsp_data`.

Top module: `smi_window_bridge`

## Requirements
- R1: The addressing mode and own address are taken from `strap_addr` only while `rst_n` is low. Single-chip mode is selected when the straps are all zero, and the own address is {strap_addr, 1'b0}. Changing the straps after reset has no effect.
- R2: In single-chip mode every frame starts an internal access with device = `frame_phy`, register = `frame_reg`. A read returns the bus read data on `rsp_valid`; a write forwards `frame_wdata`. A frame that arrives while a bus request is outstanding is dropped.
- R3: In multi-chip mode a frame at any PHY address other than the own address produces no response, no bus access and no register change.
- R4: At the own address, register 0 reads as the command word with busy in bit 15, and register 1 reads as the data register. Every other register reads 0xFFFF, and writes to it are discarded. A window read answers on the cycle after the frame.
- R5: A command write with bit 15 = 1, bit 12 = 1 and opcode bits 11:10 = 01 (write) or 10 (read) sets busy. It then raises `bus_req` with device = bits 9:5 and register = bits 4:0. A command written with bit 15 = 0 is stored but launches nothing.
- R6: An indirect write drives the data register contents on `bus_wdata`.
- R7: Busy stays set until the acknowledge and reads 0 from the cycle after it. For a read, `bus_rdata` is captured into the data register at that acknowledge.
- R8: A command with bit 15 set but bit 12 = 0 or opcode 00/11 pulses `cmd_reject` for one cycle on the cycle after the frame. It does not raise `bus_req` and leaves busy clear.
- R9: While busy is set, writes to the command and the data registers are ignored.
- R10: Reset clears the command register, the data register and busy.
- R11: Once raised, `bus_req` and its fields hold unchanged until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_addr | input | 4 | Address straps, bits 4:1 of the device address |
| frame_valid | input | 1 | One-cycle strobe of a decoded management frame |
| frame_phy | input | 5 | PHY address of the frame |
| frame_reg | input | 5 | Register number of the frame |
| frame_wr | input | 1 | 1 = write frame, 0 = read frame |
| frame_wdata | input | 16 | Write data of the frame |
| rsp_valid | output | 1 | One-cycle pulse: read response available |
| rsp_data | output | 16 | Read response data |
| cmd_reject | output | 1 | One-cycle pulse: malformed command refused |
| bus_req | output | 1 | Internal register-bus request |
| bus_wr | output | 1 | Internal access is a write |
| bus_dev | output | 5 | Internal device number |
| bus_reg | output | 5 | Internal register number |
| bus_wdata | output | 16 | Internal write data |
| bus_ack | input | 1 | Internal access complete |
| bus_rdata | input | 16 | Internal read data, valid with bus_ack |

## Verification
The bench sweeps all 32 PHY addresses in both modes with different acknowledge delays. A design that mis-decoded the own address or leaked answers from foreign addresses would return a response or start a bus access where none belongs. It changes the straps after reset, so a design that samples them continuously would flip modes. It fires commands and data writes while busy and checks that a single bus write carries the original data. It issues malformed mode and opcode combinations, which a lax decoder would launch. Finally it reads busy on the cycle after acknowledge, where an off-by-one clear would still show 1.

// File: rtl/smi_bridge_pkg.sv
// Shared constants and types of the strap-addressed management bridge.
// Assumes clause-22 field widths: 5-bit addresses, 16-bit data.
package smi_bridge_pkg;
    localparam int DEV_W    = 5;
    localparam int REG_W    = 5;
    localparam int DATA_W   = 16;
    localparam int STRAP_W  = DEV_W - 1;
    localparam int BUSY_BIT = DATA_W - 1;
    localparam int MODE_BIT = 12;
    localparam int OP_LSB   = 10;
    localparam int DEV_LSB  = REG_W;
    localparam logic [DATA_W-1:0] UNMAPPED = '1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_BAD   = 2'b11
    } op_e;

    typedef struct packed {
        logic              wr;
        logic [DEV_W-1:0]  dev;
        logic [REG_W-1:0]  regn;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;
endpackage

// File: rtl/smi_mode_latch.sv
// Captures addressing mode and own address from the straps.
// Assumes straps are stable during reset; ignores them afterwards.
module smi_mode_latch
    import smi_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_addr,
    output logic               single_mode,
    output logic [DEV_W-1:0]   own_addr
);
    // Sample straps only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_mode <= (strap_addr == '0);
            own_addr    <= {strap_addr, 1'b0};
        end
    end
endmodule

// File: rtl/smi_bus_port.sv
// Request/acknowledge register-bus master. Holds one access until acked.
// Assumes start is only honoured when no request is outstanding.
module smi_bus_port
    import smi_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  bus_cmd_t          start_cmd,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [DEV_W-1:0]  bus_dev,
    output logic [REG_W-1:0]  bus_reg,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    output logic              done
);
    bus_cmd_t cmd_q;
    logic     req_q;

    // Raise a request on start, drop it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            cmd_q <= '0;
        end else if (req_q && bus_ack) begin
            req_q <= 1'b0;
        end else if (start && !req_q) begin
            req_q <= 1'b1;
            cmd_q <= start_cmd;
        end
    end

    // Present held request fields and flag completion.
    always_comb begin
        bus_req   = req_q;
        bus_wr    = cmd_q.wr;
        bus_dev   = cmd_q.dev;
        bus_reg   = cmd_q.regn;
        bus_wdata = cmd_q.wdata;
        done      = req_q && bus_ack;
    end
endmodule

// File: rtl/smi_window_regs.sv
// Command and data window registers for multi-chip mode.
// Decodes command words, launches internal accesses, tracks busy.
// Assumes strobes are already qualified by own-address hit.
module smi_window_regs
    import smi_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [REG_W-1:0]  regn,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              launch,
    output bus_cmd_t          launch_cmd,
    output logic              reject,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data
);
    logic [BUSY_BIT-1:0] cmd_q;
    logic [DATA_W-1:0]   data_q;
    logic                busy_q;
    logic                rd_pend_q;
    logic                reject_q;
    logic                cmd_wr;
    logic                cmd_go;
    logic                cmd_ok;
    op_e                 op;

    // Decode a command write at offset 0.
    always_comb begin
        op     = op_e'(wdata[OP_LSB+1:OP_LSB]);
        cmd_wr = wr_strobe && !busy_q && (regn == REG_W'(0));
        cmd_go = cmd_wr && wdata[BUSY_BIT];
        cmd_ok = wdata[MODE_BIT] && (op == OP_WRITE || op == OP_READ);
        launch = cmd_go && cmd_ok;
        launch_cmd.wr    = (op == OP_WRITE);
        launch_cmd.dev   = wdata[DEV_LSB+DEV_W-1:DEV_LSB];
        launch_cmd.regn  = wdata[REG_W-1:0];
        launch_cmd.wdata = data_q;
    end

    // Update window registers, busy and reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            data_q    <= '0;
            busy_q    <= 1'b0;
            rd_pend_q <= 1'b0;
            reject_q  <= 1'b0;
        end else begin
            reject_q <= 1'b0;
            if (bus_done) begin
                busy_q <= 1'b0;
                if (rd_pend_q) data_q <= bus_rdata;
            end else if (cmd_wr) begin
                cmd_q <= wdata[BUSY_BIT-1:0];
                if (launch) begin
                    busy_q    <= 1'b1;
                    rd_pend_q <= (op == OP_READ);
                end else if (cmd_go) begin
                    reject_q <= 1'b1;
                end
            end else if (wr_strobe && !busy_q && regn == REG_W'(1)) begin
                data_q <= wdata;
            end
        end
    end

    // Read multiplexer over the window offsets.
    always_comb begin
        busy   = busy_q;
        reject = reject_q;
        case (regn)
            REG_W'(0): rd_data = {busy_q, cmd_q};
            REG_W'(1): rd_data = data_q;
            default:   rd_data = UNMAPPED;
        endcase
    end
endmodule

// File: rtl/smi_window_bridge.sv
// Top of the strap-addressed management bridge. Routes decoded frames
// either straight to the internal bus (single-chip) or through the
// command/data window at the own address (multi-chip).
// Assumes frames are one-cycle strobes from an upstream MDIO decoder.
module smi_window_bridge
    import smi_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               frame_valid,
    input  logic [DEV_W-1:0]   frame_phy,
    input  logic [REG_W-1:0]   frame_reg,
    input  logic               frame_wr,
    input  logic [DATA_W-1:0]  frame_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               cmd_reject,
    output logic               bus_req,
    output logic               bus_wr,
    output logic [DEV_W-1:0]   bus_dev,
    output logic [REG_W-1:0]   bus_reg,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_rdata
);
    logic              single_mode;
    logic [DEV_W-1:0]  own_addr;
    logic              own_hit;
    logic              dir_start;
    logic              win_launch;
    bus_cmd_t          win_cmd;
    bus_cmd_t          dir_cmd;
    logic              win_busy;
    logic [DATA_W-1:0] win_rd_data;
    logic              port_start;
    bus_cmd_t          port_cmd;
    logic              bus_done;
    logic              dir_rd_q;

    smi_mode_latch u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_addr  (strap_addr),
        .single_mode (single_mode),
        .own_addr    (own_addr)
    );

    // Qualify frames by mode and address.
    always_comb begin
        own_hit       = frame_valid && !single_mode && (frame_phy == own_addr);
        dir_start     = frame_valid && single_mode && !bus_req;
        dir_cmd.wr    = frame_wr;
        dir_cmd.dev   = frame_phy;
        dir_cmd.regn  = frame_reg;
        dir_cmd.wdata = frame_wdata;
        port_start    = single_mode ? dir_start : win_launch;
        port_cmd      = single_mode ? dir_cmd : win_cmd;
    end

    smi_window_regs u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_strobe  (own_hit && frame_wr),
        .regn       (frame_reg),
        .wdata      (frame_wdata),
        .bus_done   (bus_done && !single_mode),
        .bus_rdata  (bus_rdata),
        .launch     (win_launch),
        .launch_cmd (win_cmd),
        .reject     (cmd_reject),
        .busy       (win_busy),
        .rd_data    (win_rd_data)
    );

    smi_bus_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (port_start),
        .start_cmd (port_cmd),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_dev   (bus_dev),
        .bus_reg   (bus_reg),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .done      (bus_done)
    );

    // Track whether the outstanding direct access is a read.
    always_ff @(posedge clk) begin
        if (!rst_n)          dir_rd_q <= 1'b0;
        else if (dir_start)  dir_rd_q <= !frame_wr;
        else if (bus_done)   dir_rd_q <= 1'b0;
    end

    // Register the host-side read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (single_mode) begin
                if (bus_done && dir_rd_q) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= bus_rdata;
                end
            end else if (own_hit && !frame_wr) begin
                rsp_valid <= 1'b1;
                rsp_data  <= win_rd_data;
            end
        end
    end
endmodule

// File: rtl/smi_window_bridge_chk.sv
// Property checker for the management bridge, bound to the top.
// Observes ports and the window busy flag; drives nothing.
module smi_window_bridge_chk
    import smi_bridge_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_valid,
    input logic [DEV_W-1:0]  frame_phy,
    input logic              single_mode,
    input logic [DEV_W-1:0]  own_addr,
    input logic              rsp_valid,
    input logic              cmd_reject,
    input logic              busy,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [DEV_W-1:0]  bus_dev,
    input logic [REG_W-1:0]  bus_reg,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack
);
    // R11: request and fields hold until acknowledge.
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable({bus_wr, bus_dev, bus_reg, bus_wdata}));

    // R7: busy clears on the cycle after acknowledge.
    p_busy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bus_req && bus_ack |=> !busy);

    // R7: busy holds while no acknowledge arrives.
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(bus_req && bus_ack) |=> busy);

    // R8: a rejected command leaves the bus idle and busy clear.
    p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> !busy && !bus_req);

    // R3: foreign addresses get no answer in multi-chip mode.
    p_foreign_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && !single_mode && frame_phy != own_addr |=> !rsp_valid);

    // R1: mode does not move outside reset.
    p_mode_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(single_mode) && $stable(own_addr));
endmodule

bind smi_window_bridge smi_window_bridge_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_phy   (frame_phy),
    .single_mode (single_mode),
    .own_addr    (own_addr),
    .rsp_valid   (rsp_valid),
    .cmd_reject  (cmd_reject),
    .busy        (win_busy),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_dev     (bus_dev),
    .bus_reg     (bus_reg),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack)
);

// File: tb/test_smi_window_bridge.sv
module test_smi_window_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_addr = 4'd3;
    logic        frame_valid = 1'b0;
    logic [4:0]  frame_phy = '0;
    logic [4:0]  frame_reg = '0;
    logic        frame_wr = 1'b0;
    logic [15:0] frame_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        cmd_reject;
    logic        bus_req, bus_wr;
    logic [4:0]  bus_dev, bus_reg;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;

    int tests = 0;
    int fails = 0;
    int ack_delay = 0;
    int wait_cnt = 0;
    int txn_cnt = 0;
    logic [4:0]  last_wr_dev, last_wr_reg;
    logic [15:0] last_wr_data;
    bit finished = 0;

    always #5 clk = ~clk;

    smi_window_bridge i_smi_window_bridge (.*);

    function automatic logic [15:0] model(input logic [4:0] d, input logic [4:0] r);
        return {d, r, 6'(d * 3 + r)};
    endfunction

    // Internal bus responder with programmable acknowledge delay.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (wait_cnt >= ack_delay) begin
                    bus_ack   = 1'b1;
                    bus_rdata = bus_wr ? 16'hDEAD : model(bus_dev, bus_reg);
                    if (bus_wr) begin
                        last_wr_dev  = bus_dev;
                        last_wr_reg  = bus_reg;
                        last_wr_data = bus_wdata;
                    end
                    txn_cnt++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        strap_addr = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic frame(input logic [4:0] p, input logic [4:0] r, input bit wr, input logic [15:0] d);
        @(negedge clk);
        frame_valid = 1'b1;
        frame_phy = p;
        frame_reg = r;
        frame_wr = wr;
        frame_wdata = d;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int lim, output bit got, output logic [15:0] d);
        got = 0;
        d = '0;
        for (int i = 0; i < lim; i++) begin
            if (rsp_valid) begin
                got = 1;
                d = rsp_data;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [4:0] p, input logic [4:0] r, output bit got, output logic [15:0] d);
        frame(p, r, 0, 16'h0);
        wait_rsp(40, got, d);
    endtask

    task automatic poll_idle(input logic [4:0] own, output bit ok);
        bit g;
        logic [15:0] d;
        ok = 0;
        for (int i = 0; i < 60; i++) begin
            rd(own, 5'd0, g, d);
            if (g && !d[15]) begin
                ok = 1;
                return;
            end
        end
    endtask

    initial begin
        bit g, ok;
        logic [15:0] d;
        int t0;
        logic [15:0] c;

        // ---- multi-chip, own address 6 ----
        do_reset(4'd3);
        rd(5'd6, 5'd0, g, d);
        chk(g && d == 16'h0, "R10 reset cmd", d, 16'h0);
        rd(5'd6, 5'd1, g, d);
        chk(g && d == 16'h0, "R10 reset data", d, 16'h0);

        strap_addr = 4'd0;  // R1: must not switch to single-chip
        frame(5'd6, 5'd1, 1, 16'hBEEF);
        rd(5'd6, 5'd1, g, d);
        chk(g && d == 16'hBEEF, "R1 strap change ignored, own reg1", d, 16'hBEEF);
        rd(5'd6, 5'd2, g, d);
        chk(g && d == 16'hFFFF, "R4 unmapped reg", d, 16'hFFFF);

        // R3: foreign sweep
        t0 = txn_cnt;
        for (int p = 0; p < 32; p++) begin
            if (p == 6) continue;
            frame(5'(p), 5'd1, 1, 16'hAAAA);
            frame(5'(p), 5'd0, 0, 16'h0);
            wait_rsp(4, g, d);
            chk(!g, "R3 foreign answered", d, 16'h0);
        end
        chk(txn_cnt == t0, "R3 foreign bus access", 16'(txn_cnt - t0), 16'h0);
        rd(5'd6, 5'd1, g, d);
        chk(g && d == 16'hBEEF, "R3 foreign write leaked", d, 16'hBEEF);

        // R4: writes to unmapped offsets discarded
        frame(5'd6, 5'd7, 1, 16'h5555);
        rd(5'd6, 5'd7, g, d);
        chk(g && d == 16'hFFFF, "R4 unmapped write", d, 16'hFFFF);
        rd(5'd6, 5'd1, g, d);
        chk(g && d == 16'hBEEF, "R4 data untouched", d, 16'hBEEF);

        // R5/R7: indirect read sweep over all devices
        for (int dv = 0; dv < 32; dv++) begin
            logic [4:0] rg = 5'((dv * 7) % 32);
            ack_delay = (dv % 4) + 6;
            c = 16'h9800 | 16'(dv << 5) | 16'(rg);
            frame(5'd6, 5'd0, 1, c);
            rd(5'd6, 5'd0, g, d);
            chk(g && d[15], "R5 busy after launch", d, c);
            poll_idle(5'd6, ok);
            chk(ok, "R7 busy never cleared", 16'h0, 16'h0);
            rd(5'd6, 5'd1, g, d);
            chk(g && d == model(5'(dv), rg), "R7 read data", d, model(5'(dv), rg));
        end

        // R7: busy reads 0 right after acknowledge
        ack_delay = 8;
        frame(5'd6, 5'd0, 1, 16'h9800 | 16'(9 << 5) | 16'd2);
        @(posedge clk);
        while (!bus_ack) @(posedge clk);
        rd(5'd6, 5'd0, g, d);
        chk(g && !d[15], "R7 busy cycle after ack", d, 16'h1800 | 16'(9 << 5) | 16'd2);
        rd(5'd6, 5'd1, g, d);
        chk(g && d == model(5'd9, 5'd2), "R7 data at ack", d, model(5'd9, 5'd2));

        // R6: indirect write sweep
        for (int dv = 0; dv < 32; dv += 3) begin
            logic [15:0] wd = 16'(16'h3000 + dv * 257);
            ack_delay = dv % 5;
            t0 = txn_cnt;
            frame(5'd6, 5'd1, 1, wd);
            frame(5'd6, 5'd0, 1, 16'h9400 | 16'(dv << 5) | 16'(31 - dv));
            poll_idle(5'd6, ok);
            chk(ok && txn_cnt == t0 + 1, "R5 one write access", 16'(txn_cnt - t0), 16'h1);
            chk(last_wr_dev == 5'(dv) && last_wr_reg == 5'(31 - dv), "R5 write target",
                {6'h0, last_wr_dev, last_wr_reg}, {6'h0, 5'(dv), 5'(31 - dv)});
            chk(last_wr_data == wd, "R6 write data", last_wr_data, wd);
        end

        // R9: writes while busy ignored
        ack_delay = 10;
        t0 = txn_cnt;
        frame(5'd6, 5'd1, 1, 16'h1111);
        frame(5'd6, 5'd0, 1, 16'h9400 | 16'(3 << 5) | 16'd4);
        frame(5'd6, 5'd1, 1, 16'h2222);
        frame(5'd6, 5'd0, 1, 16'h9400 | 16'(5 << 5) | 16'd6);
        poll_idle(5'd6, ok);
        repeat (15) @(negedge clk);
        chk(txn_cnt == t0 + 1, "R9 extra access", 16'(txn_cnt - t0), 16'h1);
        chk(last_wr_data == 16'h1111 && last_wr_dev == 5'd3, "R9 write data", last_wr_data, 16'h1111);
        rd(5'd6, 5'd1, g, d);
        chk(g && d == 16'h1111, "R9 data reg", d, 16'h1111);
        rd(5'd6, 5'd0, g, d);
        chk(g && d == 16'h1464, "R9 cmd reg", d, 16'h1464);

        // R8: malformed commands
        ack_delay = 0;
        foreach (c_list[k]) begin
            t0 = txn_cnt;
            frame(5'd6, 5'd0, 1, c_list[k]);
            chk(cmd_reject, "R8 reject pulse", {15'h0, cmd_reject}, 16'h1);
            @(negedge clk);
            chk(!cmd_reject, "R8 reject one cycle", {15'h0, cmd_reject}, 16'h0);
            repeat (4) @(negedge clk);
            rd(5'd6, 5'd0, g, d);
            chk(g && !d[15] && txn_cnt == t0, "R8 no launch", d, c_list[k] & 16'h7FFF);
        end
        // R5: command without busy bit launches nothing
        t0 = txn_cnt;
        frame(5'd6, 5'd0, 1, 16'h1800 | 16'd5);
        chk(!cmd_reject, "R5 no reject without busy", {15'h0, cmd_reject}, 16'h0);
        repeat (4) @(negedge clk);
        rd(5'd6, 5'd0, g, d);
        chk(g && d == 16'h1805 && txn_cnt == t0, "R5 store only", d, 16'h1805);

        // R10: reset clears window
        do_reset(4'd3);
        rd(5'd6, 5'd1, g, d);
        chk(g && d == 16'h0, "R10 data after reset", d, 16'h0);
        rd(5'd6, 5'd0, g, d);
        chk(g && d == 16'h0, "R10 cmd after reset", d, 16'h0);

        // ---- single-chip ----
        do_reset(4'd0);
        strap_addr = 4'd5;  // R1: must stay single-chip
        for (int p = 0; p < 32; p++) begin
            logic [4:0] rg = 5'(p ^ 5);
            ack_delay = p % 3;
            rd(5'(p), rg, g, d);
            chk(g && d == model(5'(p), rg), "R2 direct read", d, model(5'(p), rg));
        end
        for (int p = 0; p < 32; p += 4) begin
            t0 = txn_cnt;
            frame(5'(p), 5'(p + 1), 1, 16'(16'hC000 + p));
            repeat (6) @(negedge clk);
            chk(txn_cnt == t0 + 1 && last_wr_dev == 5'(p) && last_wr_reg == 5'(p + 1),
                "R2 direct write target", {6'h0, last_wr_dev, last_wr_reg}, {6'h0, 5'(p), 5'(p + 1)});
            chk(last_wr_data == 16'(16'hC000 + p), "R2 direct write data", last_wr_data, 16'(16'hC000 + p));
        end
        // R2: frame during outstanding request dropped
        ack_delay = 6;
        t0 = txn_cnt;
        frame(5'd2, 5'd3, 1, 16'h0101);
        frame(5'd4, 5'd5, 1, 16'h0202);
        repeat (15) @(negedge clk);
        chk(txn_cnt == t0 + 1 && last_wr_data == 16'h0101, "R2 drop while pending", last_wr_data, 16'h0101);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    logic [15:0] c_list [3] = '{16'h8800, 16'h9C00, 16'h9000};

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %h expected %h", 16'h1, 16'h0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule